// File: doc/BRIEF.md
# Automatic Mute Pin Controller

This block drives a board-level mute pin together with its output enable, so an outboard circuit can silence the analog stage after a converter. The pin is driven high by any of three sources: a manual request from the control registers, an automatic request raised once every channel has carried exact zero samples for a long run, or an automatic request raised while a serial-clock error is flagged. Each automatic source has its own enable bit. The clock-error flag is generated elsewhere and arrives as an input.

Before an automatic source raises the pin, the block asks the digital path to mute its outputs. It waits for a ramp-done acknowledge, or for a timeout counted in sample strobes, so that the outboard circuit never switches while a loud signal is still present. Manual requests drive the pin directly. While the power-down bit is set, or after reset, the pin is not driven and all counters are cleared. All pin and request changes happen on sample strobes, except power-down, which acts on the next clock.

Top module: `mute_pin_ctrl`

## Requirements
- R1: While `rst` or `pdn_i` is high, the next clock edge leaves `pin_oe_o`, `pin_o` and `dig_mute_req_o` low and clears all counters.
- R2: With `rst` and `pdn_i` low, `pin_oe_o` is high after the next clock edge.
- R3: A strobe with `man_req_i` high sets `pin_o` at that edge with no digital mute request; without a strobe `pin_o` holds its value.
- R4: With `zero_en_i` high, after `ZERO_RUN` consecutive strobes on which every channel of `smp_data_i` is zero, the next strobe raises `dig_mute_req_o`.
- R5: A strobe on which any channel is nonzero restarts the zero run, so a full `ZERO_RUN` zero strobes are needed again.
- R6: A strobe with `clk_err_i` and `clkerr_en_i` high raises `dig_mute_req_o` at that edge.
- R7: An automatic source sets `pin_o` only on a strobe after `dig_mute_req_o` is already high and `ramp_done_i` is high on that strobe; an acknowledge held high in advance still costs one strobe.
- R8: With no acknowledge, `pin_o` rises on the `ACK_TIMEOUT`-th strobe after the strobe that raised `dig_mute_req_o`.
- R9: With its enable bit low, an automatic source (zero run or clock error) raises neither `dig_mute_req_o` nor `pin_o`.
- R10: `pin_o` and `dig_mute_req_o` fall on the first strobe on which no source is active; the zero source is inactive from the strobe after the one carrying a nonzero sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_i | input | 1 | Power-down bit; pin undriven while high |
| man_req_i | input | 1 | Manual mute-pin request from registers |
| zero_en_i | input | 1 | Enable for the all-channel zero source |
| clkerr_en_i | input | 1 | Enable for the clock-error source |
| smp_stb_i | input | 1 | Sample strobe, one clock wide |
| smp_data_i | input | NUM_CH*SAMPLE_W | Samples of all channels, channel 0 in the low bits |
| clk_err_i | input | 1 | Serial-clock error flag |
| ramp_done_i | input | 1 | Digital outputs have reached full mute |
| dig_mute_req_o | output | 1 | Request to mute the digital outputs |
| pin_o | output | 1 | Mute pin level |
| pin_oe_o | output | 1 | Mute pin output enable |

## Verification
The zero detector is fed runs of exact zeros of full length, runs broken one strobe short of the limit, and zeros with its enable low, which separates a correct restart of the count from an off-by-one and from a missing enable gate. The clock-error source is run once with the acknowledge held high ahead of time and once with no acknowledge, which tells the ordering rule apart from the timeout path and pins the timeout length to the strobe. Manual requests are given with and without strobes and across a power-down, which separates strobe-qualified updates from the immediate clearing of power-down.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARMED = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mpc_zero_det.sv
module mpc_zero_det #(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 8192
) (
  input  logic                       clk,
  input  logic                       clr_i,
  input  logic                       stb_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] data_i,
  output logic                       run_done_o
);
  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(ZERO_RUN);

  logic [NUM_CH-1:0] ch_zero;
  logic              all_zero;
  logic [CW-1:0]     cnt_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_zero[c] = (data_i[c*SAMPLE_W +: SAMPLE_W] == '0);
  end
  assign all_zero = &ch_zero;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (!all_zero)            cnt_q <= '0;
      else if (cnt_q != RUN_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_done_o = (cnt_q == RUN_MAX);

  p_restart_r5: assert property (@(posedge clk) disable iff (clr_i)
    stb_i && !all_zero |=> cnt_q == '0);
  p_no_skip_r4: assert property (@(posedge clk) disable iff (clr_i)
    !stb_i |=> $stable(cnt_q));
endmodule

// File: rtl/mpc_seq.sv
module mpc_seq
  import mpc_pkg::*;
#(
  parameter int ACK_TIMEOUT = 1024
) (
  input  logic clk,
  input  logic clr_i,
  input  logic stb_i,
  input  logic auto_req_i,
  input  logic ack_i,
  output logic mute_req_o,
  output logic armed_d_o
);
  localparam int TW = (ACK_TIMEOUT > 2) ? $clog2(ACK_TIMEOUT) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(ACK_TIMEOUT - 1);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          req_q;

  always_comb begin
    st_d  = st_q;
    tmo_d = tmo_q;
    if (!auto_req_i) begin
      st_d  = ST_IDLE;
      tmo_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d  = ST_WAIT;
          tmo_d = '0;
        end
        ST_WAIT: begin
          if (ack_i || tmo_q == TMO_LAST) st_d = ST_ARMED;
          else                            tmo_d = tmo_q + 1'b1;
        end
        default: st_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr_i) begin
      st_q  <= ST_IDLE;
      tmo_q <= '0;
      req_q <= 1'b0;
    end else if (stb_i) begin
      st_q  <= st_d;
      tmo_q <= tmo_d;
      req_q <= auto_req_i;
    end
  end

  assign mute_req_o = req_q;
  assign armed_d_o  = (st_d == ST_ARMED);

  p_req_on_auto_r6: assert property (@(posedge clk) disable iff (clr_i)
    stb_i && auto_req_i |=> mute_req_o);
  p_busy_has_req_r7: assert property (@(posedge clk) disable iff (clr_i)
    st_q != ST_IDLE |-> req_q);
endmodule

// File: rtl/mute_pin_ctrl.sv
module mute_pin_ctrl #(
  parameter int NUM_CH      = 6,
  parameter int SAMPLE_W    = 24,
  parameter int ZERO_RUN    = 8192,
  parameter int ACK_TIMEOUT = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pdn_i,
  input  logic                       man_req_i,
  input  logic                       zero_en_i,
  input  logic                       clkerr_en_i,
  input  logic                       smp_stb_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_data_i,
  input  logic                       clk_err_i,
  input  logic                       ramp_done_i,
  output logic                       dig_mute_req_o,
  output logic                       pin_o,
  output logic                       pin_oe_o
);
  logic clr;
  logic zero_run;
  logic auto_req;
  logic armed_d;
  logic pin_q, oe_q;

  assign clr = rst | pdn_i;

  mpc_zero_det #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .ZERO_RUN(ZERO_RUN)
  ) i_zero (
    .clk       (clk),
    .clr_i     (clr),
    .stb_i     (smp_stb_i),
    .data_i    (smp_data_i),
    .run_done_o(zero_run)
  );

  assign auto_req = (zero_en_i & zero_run) | (clkerr_en_i & clk_err_i);

  mpc_seq #(
    .ACK_TIMEOUT(ACK_TIMEOUT)
  ) i_seq (
    .clk       (clk),
    .clr_i     (clr),
    .stb_i     (smp_stb_i),
    .auto_req_i(auto_req),
    .ack_i     (ramp_done_i),
    .mute_req_o(dig_mute_req_o),
    .armed_d_o (armed_d)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= 1'b1;
      if (smp_stb_i) pin_q <= man_req_i | armed_d;
    end
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = oe_q;

  p_undriven_r1: assert property (@(posedge clk) disable iff (rst)
    pdn_i |=> !pin_oe_o && !pin_o && !dig_mute_req_o);
  p_manual_r3: assert property (@(posedge clk) disable iff (rst)
    smp_stb_i && man_req_i && !pdn_i |=> pin_o);
  p_mute_first_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_o) && !$past(man_req_i) |-> $past(dig_mute_req_o));
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    smp_stb_i && !pdn_i && !man_req_i && !auto_req |=> !pin_o && !dig_mute_req_o);
endmodule

// File: tb/test_mute_pin_ctrl.sv
module test_mute_pin_ctrl;
  localparam int NCH = 3;
  localparam int SW  = 8;
  localparam int ZR  = 16;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst, pdn, man, zen, cen, stb, cerr, ack;
  logic [NCH*SW-1:0] data;
  logic dmr, pin, oe;

  typedef struct {
    bit    p;
    bit    d;
    bit    o;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;

  always #5 clk = ~clk;

  mute_pin_ctrl #(.NUM_CH(NCH), .SAMPLE_W(SW), .ZERO_RUN(ZR), .ACK_TIMEOUT(TMO)) i_mute_pin_ctrl (
    .clk(clk), .rst(rst), .pdn_i(pdn), .man_req_i(man), .zero_en_i(zen),
    .clkerr_en_i(cen), .smp_stb_i(stb), .smp_data_i(data), .clk_err_i(cerr),
    .ramp_done_i(ack), .dig_mute_req_o(dmr), .pin_o(pin), .pin_oe_o(oe)
  );

  // driver side: one clock, then push what the requirements predict
  task automatic tick(input bit e_pin, input bit e_dm, input bit e_oe, input string tag);
    exp_t it;
    @(posedge clk);
    it.p = e_pin; it.d = e_dm; it.o = e_oe; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  // monitor side: compare after outputs settle
  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (pin !== it.p || dmr !== it.d || oe !== it.o) begin
        failures++;
        $display("FAIL %s: pin/dm/oe actual=%b%b%b expected=%b%b%b",
                 it.tag, pin, dmr, oe, it.p, it.d, it.o);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; pdn = 1; man = 0; zen = 0; cen = 0; stb = 1; cerr = 0; ack = 0;
    data = 24'h010203;
    @(negedge clk);
    tick(0, 0, 0, "R1 reset");
    tick(0, 0, 0, "R1 reset");
    rst = 0;
    tick(0, 0, 0, "R1 pdn");
    pdn = 0;
    tick(0, 0, 1, "R2 oe");
    // manual
    man = 1; tick(1, 0, 1, "R3 manual");
    man = 0; tick(0, 0, 1, "R10 manual release");
    // clock error, ack held high in advance
    cen = 1; ack = 1; cerr = 1;
    tick(0, 1, 1, "R6 clkerr req");
    tick(1, 1, 1, "R7 ack pin");
    cerr = 0; tick(0, 0, 1, "R10 clkerr release");
    // clock error, no ack -> timeout
    ack = 0; cerr = 1;
    tick(0, 1, 1, "R6 clkerr req");
    for (int i = 0; i < TMO - 1; i++) tick(0, 1, 1, "R8 waiting");
    tick(1, 1, 1, "R8 timeout pin");
    cerr = 0; tick(0, 0, 1, "R10 release");
    // zero run
    zen = 1; ack = 1; data = '0;
    for (int i = 0; i < ZR; i++) tick(0, 0, 1, "R4 counting");
    tick(0, 1, 1, "R4 zero req");
    tick(1, 1, 1, "R7 zero pin");
    data = 24'h000100;
    tick(1, 1, 1, "R10 nonzero strobe");
    tick(0, 0, 1, "R10 zero release");
    // broken run
    data = '0;
    for (int i = 0; i < ZR - 1; i++) tick(0, 0, 1, "R5 short run");
    data = 24'h800000;
    tick(0, 0, 1, "R5 break");
    data = '0;
    for (int i = 0; i < ZR; i++) tick(0, 0, 1, "R5 recount");
    tick(0, 1, 1, "R5 full run req");
    data = 24'h000001;
    tick(1, 1, 1, "R7 pin");
    tick(0, 0, 1, "R10 release");
    // enables low
    zen = 0; data = '0;
    for (int i = 0; i < ZR + 4; i++) tick(0, 0, 1, "R9 zero disabled");
    cen = 0; cerr = 1;
    for (int i = 0; i < 3; i++) tick(0, 0, 1, "R9 clkerr disabled");
    cerr = 0; data = 24'h111111;
    // strobe qualification and power-down
    stb = 0; man = 1;
    tick(0, 0, 1, "R3 no strobe");
    tick(0, 0, 1, "R3 no strobe");
    stb = 1; tick(1, 0, 1, "R3 strobe");
    stb = 0; man = 0; tick(1, 0, 1, "R3 hold");
    man = 1; stb = 1; pdn = 1; tick(0, 0, 0, "R1 pdn mid-run");
    pdn = 0; man = 0; tick(0, 0, 1, "R2 oe back");
    @(posedge clk); #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule